// File: doc/BRIEF.md
# Timer Capture/Compare Channel

A single event channel that sits beside a free-running reference timer. Software configures it through an 8-bit control register and a timer-wide event-time register, both reached over a simple write/read bus. The timer value arrives on an input port every cycle.

In capture mode the channel watches an external input pin. The pin passes through a synchroniser, and the channel detects edges on it. When an edge of the selected polarity arrives, the channel stores the current timer value in the event-time register and raises an event-pending flag. If a second edge arrives before software has read the captured time, an overrun flag is raised and the newer timestamp replaces the older one. Reading the event-time register clears both flags.

In compare mode the channel checks every cycle whether the timer equals the event-time register. On a match it clears, sets or toggles its output pin, or leaves the pin alone. A re-enable bit chooses between a compare that fires once and then stays idle until the event time is rewritten, and a compare that acts on every match.

Top module: `evt_channel`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 00h, which selects capture mode with no capture. The event-time register reads 0, and the event flag, the overrun flag and the output pin are all 0.
- R2: In capture mode (control bit 6 = 0), the field in control bits 5:4 picks the capturing edge: 00 none, 01 falling, 10 rising, 11 either. A pin level applied before clock edge k is synchronised, and the timer value present at edge k+2 is stored in the event-time register.
- R3: A capture sets the event flag. A bus read of the event-time register (rd_en=1, rd_sel=1) clears it, unless a capture happens in that same cycle.
- R4: A capture while the event flag is already set, and not being cleared in that cycle, sets the overrun flag and overwrites the stored time with the new timer value. A read of the event-time register clears the overrun flag.
- R5: In compare mode (control bit 6 = 1), when the timer equals the event-time register, the action in control bits 5:4 is applied to the output pin at that clock edge: 00 no change, 01 drive 0, 10 drive 1, 11 invert.
- R6: With control bit 3 = 0, only the first match acts. Later matches do nothing until the event-time register is written again, and that write re-arms the compare.
- R7: With control bit 3 = 1, every cycle in which the timer equals the event time performs the action.
- R8: Writing the control register never changes the output pin. The pin changes only on a compare action.
- R9: In compare mode, edges on the input pin change neither the event-time register nor the event flag.
- R10: Reads are combinational. rd_sel=0 returns the control byte in bits 7:0 with zeros above it, and rd_sel=1 returns the event-time register. A write with wr_sel=0 loads the control register from wr_data[7:0], and a write with wr_sel=1 loads the event-time register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 event time |
| wr_data | input | TIMER_W | Write data |
| rd_en | input | 1 | Read strobe; a read of the event time clears the flags |
| rd_sel | input | 1 | Read source: 0 control, 1 event time |
| rd_data | output | TIMER_W | Read data |
| timer | input | TIMER_W | Reference timer value |
| pin_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Compare output pin |
| evt_flag | output | 1 | Capture event pending |
| ovr_flag | output | 1 | Capture overrun |

## Verification
The assertions assume that pin_in is low while reset is asserted, so that no edge is seen on the first cycle after reset. They also assume that software does not write the event-time register in the same cycle as a capture it expects to keep. The stimulus holds the timer at 0 while it changes the configuration, and it draws compare times from a range that starts at 1, so that no match occurs by accident. Pin edges are driven only between clock edges, and each one is held long enough for the synchroniser to pass it through.

// File: rtl/evt_pkg.sv
// Shared definitions for the capture/compare channel.
// Assumes an 8-bit control byte whose field positions are fixed by software.
package evt_pkg;
    localparam int CTRL_W   = 8;
    localparam int CE_BIT   = 6;
    localparam int MODE_HI  = 5;
    localparam int MODE_LO  = 4;
    localparam int REARM_BIT = 3;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_CLEAR  = 2'b01,
        ACT_SET    = 2'b10,
        ACT_INVERT = 2'b11
    } cmp_act_e;
endpackage

// File: rtl/evt_edge_sync.sv
// Synchroniser chain plus edge detector for the capture input.
// Assumes din is asynchronous; STAGES must be at least 2.
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    // first stage samples the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // each further stage resamples the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // remember the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/evt_capture.sv
// Capture qualification plus event/overrun flags.
// Assumes rise/fall are single-cycle synchronous pulses.
module evt_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en,
    input  logic [1:0] edge_sel,
    input  logic       rise,
    input  logic       fall,
    input  logic       clr,
    output logic       cap_hit,
    output logic       evt_flag,
    output logic       ovr_flag
);
    assign cap_hit = cap_en & ((edge_sel[1] & rise) | (edge_sel[0] & fall));

    // event pending: set by capture, cleared by time read
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_flag <= 1'b0;
        else if (cap_hit) evt_flag <= 1'b1;
        else if (clr)     evt_flag <= 1'b0;
    end

    // overrun: capture over a pending, uncleared event
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovr_flag <= 1'b0;
        else if (cap_hit && evt_flag && !clr) ovr_flag <= 1'b1;
        else if (clr)                        ovr_flag <= 1'b0;
    end

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> evt_flag);
    assert_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_hit && evt_flag && !clr) |=> ovr_flag);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cap_hit) |=> (!evt_flag && !ovr_flag));
endmodule

// File: rtl/evt_compare.sv
// Compare engine: match detection, one-shot arming and pin action.
// Assumes evt_time changes only via software writes while ce is set.
module evt_compare
    import evt_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce,
    input  cmp_act_e           act,
    input  logic               rearm,
    input  logic               arm_set,
    input  logic [TIMER_W-1:0] timer,
    input  logic [TIMER_W-1:0] evt_time,
    output logic               pin_out
);
    logic armed;
    logic fire;

    assign fire = ce & armed & (timer == evt_time);

    // arming state: re-armed by time write, dropped after a one-shot
    always_ff @(posedge clk) begin
        if (!rst_n)              armed <= 1'b1;
        else if (arm_set)        armed <= 1'b1;
        else if (fire && !rearm) armed <= 1'b0;
    end

    // output pin driven only by a firing compare
    always_ff @(posedge clk) begin
        if (!rst_n) pin_out <= 1'b0;
        else if (fire) begin
            unique case (act)
                ACT_KEEP:   pin_out <= pin_out;
                ACT_CLEAR:  pin_out <= 1'b0;
                ACT_SET:    pin_out <= 1'b1;
                ACT_INVERT: pin_out <= ~pin_out;
            endcase
        end
    end

    assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(pin_out));
    assert_set_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act == ACT_SET) |=> pin_out);
    assert_clear_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act == ACT_CLEAR) |=> !pin_out);
    assert_invert_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act == ACT_INVERT) |=> (pin_out != $past(pin_out)));
    assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !rearm && !arm_set) |=> !armed);
endmodule

// File: rtl/evt_channel.sv
// Top of the capture/compare channel: registers, read mux and sub-units.
// Assumes TIMER_W >= 8 and a free-running timer supplied synchronously.
module evt_channel
    import evt_pkg::*;
#(
    parameter int TIMER_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [TIMER_W-1:0] wr_data,
    input  logic               rd_en,
    input  logic               rd_sel,
    output logic [TIMER_W-1:0] rd_data,
    input  logic [TIMER_W-1:0] timer,
    input  logic               pin_in,
    output logic               pin_out,
    output logic               evt_flag,
    output logic               ovr_flag
);
    localparam int PAD_W = TIMER_W - CTRL_W;

    logic [CTRL_W-1:0]  ctrl_q;
    logic [TIMER_W-1:0] time_q;
    logic rise, fall, cap_hit, time_wr, time_rd, cmp_mode;

    assign cmp_mode = ctrl_q[CE_BIT];
    assign time_wr  = wr_en & wr_sel;
    assign time_rd  = rd_en & rd_sel;

    // control register write
    always_ff @(posedge clk) begin
        if (!rst_n)              ctrl_q <= '0;
        else if (wr_en && !wr_sel) ctrl_q <= wr_data[CTRL_W-1:0];
    end

    // event-time register: software write, else capture
    always_ff @(posedge clk) begin
        if (!rst_n)       time_q <= '0;
        else if (time_wr) time_q <= wr_data;
        else if (cap_hit) time_q <= timer;
    end

    assign rd_data = rd_sel ? time_q : {{PAD_W{1'b0}}, ctrl_q};

    evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .rise(rise), .fall(fall)
    );

    evt_capture u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en(!cmp_mode),
        .edge_sel(ctrl_q[MODE_HI:MODE_LO]), .rise(rise), .fall(fall),
        .clr(time_rd), .cap_hit(cap_hit), .evt_flag(evt_flag), .ovr_flag(ovr_flag)
    );

    evt_compare #(.TIMER_W(TIMER_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .ce(cmp_mode),
        .act(cmp_act_e'(ctrl_q[MODE_HI:MODE_LO])), .rearm(ctrl_q[REARM_BIT]),
        .arm_set(time_wr), .timer(timer), .evt_time(time_q), .pin_out(pin_out)
    );

    assert_no_capture_in_compare_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode && !time_wr) |=> $stable(time_q));
    assert_ctrl_write_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !cmp_mode) |=> $stable(pin_out));
endmodule

// File: tb/evt_channel_tb.sv
module evt_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
    logic [W-1:0] wr_data = '0, timer = '0;
    logic pin_in = 1'b0;
    logic [W-1:0] rd_data;
    logic pin_out, evt_flag, ovr_flag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_channel #(.TIMER_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .timer(timer),
        .pin_in(pin_in), .pin_out(pin_out), .evt_flag(evt_flag), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected pin after a compare action
    function automatic logic apply_act(input logic [1:0] a, input logic p);
        case (a)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~p;
            default: return p;
        endcase
    endfunction

    // expected capture decision for an edge
    function automatic logic cap_expected(input logic [1:0] sel, input logic rising);
        return rising ? sel[1] : sel[0];
    endfunction

    task automatic wr(input logic sel, input logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_time(input string tag, input logic [W-1:0] exp);
        @(negedge clk); rd_sel = 1'b1; #1;
        chk(tag, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; rd_sel = 1'b0;
    endtask

    task automatic drive_pin(input logic v);
        @(negedge clk); pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic hit(input logic [W-1:0] t);
        @(negedge clk); timer = t;
        @(negedge clk); timer = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic p;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        #1;
        chk("R1 ctrl", rd_data, '0);
        chk("R1 evt", evt_flag, 0);
        chk("R1 ovr", ovr_flag, 0);
        chk("R1 pin", pin_out, 0);
        rd_sel = 1'b1; #1; chk("R1 time", rd_data, '0); rd_sel = 1'b0;

        // R10 control readback with upper bits padded
        wr(1'b0, 16'hAB20);
        #1; chk("R10 ctrl read", rd_data, 16'h0020);

        // R2 rising edge capture
        timer = 16'h1234;
        drive_pin(1'b1);
        chk("R3 flag after capture", evt_flag, 1);
        rd_time("R2 rising capture", 16'h1234);
        chk("R3 flag cleared by read", evt_flag, 0);
        // falling edge ignored with rising select
        timer = 16'h2222;
        drive_pin(1'b0);
        chk("R2 falling ignored", evt_flag, 0);
        rd_time("R2 time kept", 16'h1234);

        // R4 overrun with either-edge select
        wr(1'b0, 16'h0030);
        timer = 16'h0100; drive_pin(1'b1);
        timer = 16'h0200; drive_pin(1'b0);
        chk("R4 overrun set", ovr_flag, 1);
        rd_time("R4 newest time", 16'h0200);
        chk("R4 overrun cleared", ovr_flag, 0);

        // random capture patterns
        p = 1'b0;
        for (int i = 0; i < 30; i++) begin
            logic [1:0] sel;
            logic [W-1:0] tv;
            logic exp_hit;
            sel = 2'($urandom % 4);
            tv  = W'($urandom);
            wr(1'b0, W'({sel, 4'b0000}));
            timer = tv;
            p = ~p;
            exp_hit = cap_expected(sel, p);
            drive_pin(p);
            chk("R2 random capture flag", evt_flag, exp_hit);
            if (exp_hit) rd_time("R2 random captured time", tv);
        end
        timer = '0;
        if (p) drive_pin(1'b0);
        p = 1'b0;

        // R5 set action, R6 one-shot
        wr(1'b0, 16'h0060);
        wr(1'b1, 16'h0050);
        hit(16'h0050); chk("R5 set", pin_out, 1);
        // R8 control write leaves the pin
        wr(1'b0, 16'h0050);
        chk("R8 ctrl write keeps pin", pin_out, 1);
        hit(16'h0050); chk("R6 one-shot no second action", pin_out, 1);
        wr(1'b1, 16'h0050);
        hit(16'h0050); chk("R6 rewrite re-arms clear", pin_out, 0);

        // R7 every-match toggle
        wr(1'b0, 16'h0078);
        wr(1'b1, 16'h0300);
        hit(16'h0300); chk("R7 toggle 1", pin_out, 1);
        hit(16'h0300); chk("R7 toggle 2", pin_out, 0);
        hit(16'h0300); chk("R7 toggle 3", pin_out, 1);

        // R9 edges ignored in compare mode
        drive_pin(1'b1); drive_pin(1'b0);
        chk("R9 no flag in compare", evt_flag, 0);
        rd_time("R9 time unchanged", 16'h0300);

        // random compare patterns
        p = pin_out;
        for (int i = 0; i < 30; i++) begin
            logic [1:0] a;
            logic r;
            logic [W-1:0] t;
            a = 2'($urandom % 4);
            r = 1'($urandom % 2);
            t = W'(1 + ($urandom % 4000));
            wr(1'b0, W'({1'b1, a, r, 3'b000}));
            chk("R8 random ctrl write", pin_out, p);
            wr(1'b1, t);
            hit(t); p = apply_act(a, p);
            chk("R5 random first match", pin_out, p);
            hit(t); if (r) p = apply_act(a, p);
            chk(r ? "R7 random second match" : "R6 random second match", pin_out, p);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule